// File: doc/BRIEF.md
# Time-Ordered Capture Readout Sequencer

This block services a multichannel edge-capture unit in which each input channel latches a free-running Gray-coded count on every rising edge and raises a per-channel "count present" flag. The sequencer repeatedly takes the flag word for all channels at once. It keeps only the channels the host has enabled, and then fetches the latched count of each flagged channel one per cycle. Each fetch also clears that channel's flag inside the capture unit.

Each fetched count is converted from Gray to binary and tagged with its channel number. It is then given an age, which is the modulo-2^20 distance back from the counter value sampled together with the flag word. A small insertion sorter holds the batch in oldest-first order. The batch then drains on a valid/ready stream, so the consumer receives one merged timeline across channels. Because the age is measured modulo 2^20, a capture taken just before the counter wraps still sorts ahead of one taken just after.

Top module: `cap_readout_seq`

## Requirements
- R1: The status strobe `stat_rd` is high in the first cycle after reset and in every cycle in which no fetch is outstanding and no record is waiting. On each such cycle the block samples `cap_flags & chan_en` and `cnt_gray`.
- R2: After a status sample with a non-zero masked word, the block fetches every flagged channel exactly once. It fetches one channel per cycle on consecutive cycles, in ascending channel number, using `cap_rd` with `cap_sel`, and it starts in the cycle right after the sample.
- R3: A channel whose `chan_en` bit is 0 at the status sample is neither fetched nor reported, even if its flag is set.
- R4: The count field of a record is the binary value of the fetched Gray word. Bit k of that value is the XOR of Gray bits 19 down to k.
- R5: Within a batch, records leave in descending age, where age = (status-sample count − capture count) mod 2^20. On equal age, the lower channel goes first.
- R6: Record layout of `out_data`: bit 23 is the overrun flag, bits 22:20 are the channel number, and bits 19:0 are the binary count.
- R7: The overrun flag is 1 exactly when the record's age exceeds the parameter `OVR_AGE`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value on the next cycle. No record is lost or duplicated.
- R9: No status sample and no fetch happens while records of the current batch are still waiting. The next status sample comes in the cycle right after the last record is accepted.
- R10: While reset is asserted, `out_valid` and `cap_rd` are low on the cycle after each reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 8 | Host channel enable mask |
| cap_flags | input | 8 | Count-present flags from the capture unit |
| cnt_gray | input | 20 | Free-running counter, Gray coded |
| stat_rd | output | 1 | Status word sample strobe |
| cap_rd | output | 1 | Fetch strobe, clears the selected flag |
| cap_sel | output | 3 | Channel being fetched |
| cap_gray | input | 20 | Latched Gray count of the selected channel |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer accepts record |
| out_data | output | 24 | Record: overrun, channel, binary count |

## Verification
Two situations are targeted. In the first, a channel's new edge lands in the very cycle the status word is sampled, so it must join that batch with age zero. In the second, a fetch clears one channel's flag while another channel raises its flag in the same cycle, so that second capture must wait for the next pass. Random sparse edges on all channels, a counter started just short of wrap, a masked phase and a long stall of `out_ready` produce both situations many times, along with ties and overruns. The bench keeps queues of expected fetches and records, built from its own model of the capture unit. It compares strobe timing, fetch order and every record field on each clock.

// File: rtl/rseq_pkg.sv
// Shared widths, the sorter slot layout and the sequencer state encoding.
package rseq_pkg;
    localparam int N_CH  = 8;
    localparam int CH_W  = $clog2(N_CH);
    localparam int CNT_W = 20;
    localparam int REC_W = 1 + CH_W + CNT_W;

    typedef struct packed {
        logic             ovr;
        logic [CH_W-1:0]  ch;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] age;
    } slot_t;

    typedef enum logic [1:0] {ST_POLL, ST_READ, ST_EMIT} state_t;
endpackage

// File: rtl/rseq_gray2bin.sv
// Combinational Gray-to-binary converter.
// Assumes a standard reflected Gray code; bit k of the result is the
// XOR of all Gray bits from the MSB down to k.
module rseq_gray2bin #(
    parameter int W = 20
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    // one reduction XOR per output bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^gray[W-1:i];
    end
endmodule

// File: rtl/rseq_pick.sv
// Lowest-index picker over a request vector.
// Assumes nothing about req; idx is 0 when no bit is set.
module rseq_pick #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    // scan downward so the lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/rseq_sorter.sv
// Insertion sorter holding up to DEPTH slots, oldest (largest age) at slot 0.
// A new slot goes after all slots of equal or greater age, which keeps
// ties in arrival order. Assumes ins and pop are never high together.
module rseq_sorter
    import rseq_pkg::*;
#(
    parameter int DEPTH = N_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins,
    input  slot_t            ins_slot,
    input  logic             pop,
    output logic [REC_W-1:0] head,
    output logic             empty,
    output logic             one
);
    localparam int PW = $clog2(DEPTH + 1);

    slot_t         slot_q  [DEPTH];
    slot_t         ins_arr [DEPTH];
    slot_t         pop_arr [DEPTH];
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] pos;

    // insertion point: number of held slots at least as old as the new one
    always_comb begin
        pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (PW'(i) < cnt_q && slot_q[i].age >= ins_slot.age) pos = pos + 1'b1;
        end
    end

    // array after inserting at pos
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ins_arr[i] = (i == int'(pos)) ? ins_slot : slot_q[i];
        end
        for (int i = 1; i < DEPTH; i++) begin
            if (i > int'(pos)) ins_arr[i] = slot_q[i-1];
        end
    end

    // array after removing slot 0
    always_comb begin
        for (int i = 0; i < DEPTH - 1; i++) pop_arr[i] = slot_q[i+1];
        pop_arr[DEPTH-1] = slot_q[DEPTH-1];
    end

    // slot storage and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (ins) begin
            cnt_q <= cnt_q + 1'b1;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= ins_arr[i];
        end else if (pop && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= pop_arr[i];
        end
    end

    assign head  = {slot_q[0].ovr, slot_q[0].ch, slot_q[0].cnt};
    assign empty = (cnt_q == '0);
    assign one   = (cnt_q == PW'(1));

    // a batch never exceeds the slot count
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ins |-> cnt_q < PW'(DEPTH));

    // held slots stay in non-increasing age order
    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_ord
        assert_sorted_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (PW'(g + 1) < cnt_q) |-> slot_q[g].age >= slot_q[g+1].age);
    end
endmodule

// File: rtl/cap_readout_seq.sv
// Readout sequencer for a multichannel edge-capture unit.
// Polls the flag word, fetches flagged and enabled channels in ascending
// order (each fetch clears that flag in the capture unit), converts counts
// from Gray, orders the batch by age relative to the counter value taken
// at the poll, and streams records on valid/ready.
// Assumes cap_gray shows the selected channel's count in the cycle cap_rd
// is high, and the counter period exceeds any age that can build up.
module cap_readout_seq
    import rseq_pkg::*;
#(
    parameter int OVR_AGE = 500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  chan_en,
    input  logic [N_CH-1:0]  cap_flags,
    input  logic [CNT_W-1:0] cnt_gray,
    output logic             stat_rd,
    output logic             cap_rd,
    output logic [CH_W-1:0]  cap_sel,
    input  logic [CNT_W-1:0] cap_gray,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [REC_W-1:0] out_data
);
    localparam logic [CNT_W-1:0] OVR_LIM = CNT_W'(OVR_AGE);

    state_t           state_q;
    logic [N_CH-1:0]  pend_q;
    logic [N_CH-1:0]  pend_nx;
    logic [N_CH-1:0]  live;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] ref_bin;
    logic [CNT_W-1:0] cap_bin;
    logic [CH_W-1:0]  pick;
    logic             pick_any;
    slot_t            new_slot;
    logic             pop;
    logic             srt_empty;
    logic             srt_one;

    rseq_gray2bin #(.W(CNT_W)) u_g2b_ref (.gray(cnt_gray), .bin(ref_bin));
    rseq_gray2bin #(.W(CNT_W)) u_g2b_cap (.gray(cap_gray), .bin(cap_bin));
    rseq_pick     #(.N(N_CH))  u_pick    (.req(pend_q), .idx(pick), .any(pick_any));

    // build the slot for the channel being fetched
    always_comb begin
        new_slot.ch  = pick;
        new_slot.cnt = cap_bin;
        new_slot.age = ref_q - cap_bin;
        new_slot.ovr = new_slot.age > OVR_LIM;
    end

    rseq_sorter #(.DEPTH(N_CH)) u_sorter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins      (cap_rd),
        .ins_slot (new_slot),
        .pop      (pop),
        .head     (out_data),
        .empty    (srt_empty),
        .one      (srt_one)
    );

    assign live      = cap_flags & chan_en;
    assign pend_nx   = pend_q & ~(N_CH'(1) << pick);
    assign stat_rd   = (state_q == ST_POLL);
    assign cap_rd    = (state_q == ST_READ) && pick_any;
    assign cap_sel   = pick;
    assign out_valid = (state_q == ST_EMIT) && !srt_empty;
    assign pop       = out_valid && out_ready;

    // poll / fetch / emit sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_POLL;
            pend_q  <= '0;
            ref_q   <= '0;
        end else begin
            case (state_q)
                ST_POLL: begin
                    pend_q <= live;
                    ref_q  <= ref_bin;
                    if (live != '0) state_q <= ST_READ;
                end
                ST_READ: begin
                    pend_q <= pend_nx;
                    if (pend_nx == '0) state_q <= ST_EMIT;
                end
                ST_EMIT: begin
                    if (srt_empty || (pop && srt_one)) state_q <= ST_POLL;
                end
                default: state_q <= ST_POLL;
            endcase
        end
    end

    // consecutive fetches climb in channel number
    assert_fetch_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_rd && $past(cap_rd)) |-> cap_sel > $past(cap_sel));

    // a stalled record holds
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // once the last record goes, the next cycle polls
    assert_poll_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> stat_rd);

    // reset quiets the stream and the fetch strobe
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !cap_rd));
endmodule

// File: tb/cap_readout_seq_bench.sv
// Behavioural bench: models the capture unit, predicts fetches and records
// with queues, and compares against the ports on every clock.
module cap_readout_seq_bench;
    import rseq_pkg::*;

    localparam int OVR_T   = 12;
    localparam int RUN_CYC = 6000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [7:0]       chan_en;
    logic [7:0]       flags;
    logic [19:0]      cnt_b;
    logic [19:0]      cnt_gray;
    logic [19:0]      mem [8];
    logic             stat_rd, cap_rd, out_valid, out_ready;
    logic [2:0]       cap_sel;
    logic [19:0]      cap_gray;
    logic [23:0]      out_data;

    always #4 clk = ~clk;

    assign cnt_gray = cnt_b ^ (cnt_b >> 1);
    assign cap_gray = mem[cap_sel];

    cap_readout_seq #(.OVR_AGE(OVR_T)) u_cap_readout_seq (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cap_flags(flags),
        .cnt_gray(cnt_gray), .stat_rd(stat_rd), .cap_rd(cap_rd),
        .cap_sel(cap_sel), .cap_gray(cap_gray), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    int          rd_q[$];
    logic [23:0] exp_q[$];
    logic [23:0] bat_rec[$];
    int          bat_age[$];
    logic [7:0]  snap_en;
    logic [19:0] ref_cnt;
    bit          prev_stall = 0;
    logic [23:0] prev_data;
    int          n_ovr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] g2b(input logic [19:0] g);
        logic [19:0] b;
        b = g;
        for (int s = 1; s < 20; s = s * 2) b = b ^ (b >> s);
        return b;
    endfunction

    // one clock of checking, stimulus and model update, run at the falling edge
    task automatic step(input bit stim, input int rdy_pct, input logic [7:0] en);
        bit idle;
        idle = (rd_q.size() == 0) && (exp_q.size() == 0);
        chk(stat_rd == idle, idle ? "R1" : "R9", "status strobe", 32'(stat_rd), 32'(idle));
        if (rd_q.size() != 0) begin
            chk(cap_rd == 1'b1, "R2", "fetch strobe", 32'(cap_rd), 1);
            if (cap_rd) begin
                chk(cap_sel == 3'(rd_q[0]), "R2", "fetch channel", 32'(cap_sel), 32'(rd_q[0]));
                chk(snap_en[cap_sel], "R3", "fetch of disabled channel", 32'(snap_en), 32'(cap_sel));
            end
        end else begin
            chk(cap_rd == 1'b0, "R2", "unexpected fetch", 32'(cap_rd), 0);
        end
        if (exp_q.size() != 0 && rd_q.size() == 0) begin
            chk(out_valid == 1'b1, "R8", "record pending not offered", 32'(out_valid), 1);
            if (out_valid) begin
                chk(out_data[22:20] == exp_q[0][22:20], "R5", "channel order", 32'(out_data[22:20]), 32'(exp_q[0][22:20]));
                chk(out_data[19:0] == exp_q[0][19:0], "R4", "binary count", 32'(out_data[19:0]), 32'(exp_q[0][19:0]));
                chk(out_data[23] == exp_q[0][23], "R7", "overrun flag", 32'(out_data[23]), 32'(exp_q[0][23]));
            end
        end else begin
            chk(out_valid == 1'b0, "R6", "record without expectation", 32'(out_valid), 0);
        end
        if (prev_stall)
            chk(out_valid && out_data == prev_data, "R8", "stalled record", 32'(out_data), 32'(prev_data));

        // stimulus for the coming rising edge
        cnt_b     = cnt_b + 20'd1;
        out_ready = ($urandom_range(0, 99) < rdy_pct);
        chan_en   = en;
        for (int c = 0; c < 8; c++) begin
            if (stim && !flags[c] && !(cap_rd && cap_sel == 3'(c)) && $urandom_range(0, 99) < 3) begin
                flags[c] = 1'b1;
                mem[c]   = cnt_b ^ (cnt_b >> 1);
            end
        end

        // model update for that edge
        if (stat_rd) begin
            snap_en = chan_en;
            ref_cnt = cnt_b;
            for (int c = 0; c < 8; c++) if (flags[c] && chan_en[c]) rd_q.push_back(c);
        end
        if (cap_rd && rd_q.size() != 0) begin
            int          c;
            int          a;
            int          at;
            logic [19:0] b;
            logic [19:0] age;
            c   = rd_q.pop_front();
            b   = g2b(mem[c]);
            age = ref_cnt - b;
            a   = int'(age);
            at  = bat_age.size();
            for (int i = 0; i < bat_age.size(); i++) begin
                if (bat_age[i] < a) begin at = i; break; end
            end
            bat_age.insert(at, a);
            bat_rec.insert(at, {(a > OVR_T), 3'(c), b});
            if (a > OVR_T) n_ovr++;
            flags[c] = 1'b0;
            if (rd_q.size() == 0) begin
                foreach (bat_rec[i]) exp_q.push_back(bat_rec[i]);
                bat_rec.delete();
                bat_age.delete();
            end
        end
        if (out_valid && out_ready && exp_q.size() != 0) void'(exp_q.pop_front());
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
    endtask

    initial begin
        rst_n     = 1'b0;
        chan_en   = 8'hFF;
        flags     = '0;
        cnt_b     = 20'hFFED0;
        out_ready = 1'b0;
        for (int c = 0; c < 8; c++) mem[c] = '0;
        repeat (3) begin
            @(negedge clk);
            chk(!out_valid && !cap_rd, "R10", "reset outputs", {out_valid, cap_rd}, 0);
        end
        rst_n = 1'b1;
        for (int cyc = 0; cyc < RUN_CYC; cyc++) begin
            @(negedge clk);
            if (cyc < 1500)      step(1'b1, 75, 8'hFF);
            else if (cyc < 3000) step(1'b1, 60, 8'hA5);
            else if (cyc < 3400) step(1'b1, 0, 8'hFF);
            else                 step(1'b1, 50, 8'hFF);
        end
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            step(1'b0, 100, 8'hFF);
            if (flags == '0 && rd_q.size() == 0 && exp_q.size() == 0) break;
        end
        chk(flags == '0 && exp_q.size() == 0, "R2", "drain at end", 32'(flags), 0);
        chk(n_ovr > 0, "R7", "overrun cases seen", 32'(n_ovr), 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog expired: actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule